// File: doc/BRIEF.md
# Multi-Depth Framebuffer Pixel Unpacker

This block turns a stream of 32-bit framebuffer words into a stream of pixels, one per cycle, each a 24-bit RGB value. A word enters through a valid/ready port. The block then emits every pixel packed in that word through a second valid/ready port. Before it takes the next word, the last pixel of the current word must leave. The packing follows a 3-bit depth code and two ordering bits. Indexed depths look up their colour through a combinational palette port. Direct-colour depths widen each channel to 8 bits.

The depth, channel-swap and ordering settings, together with a 2-bit external layout select, are captured with each word when it is accepted. Software may therefore change them between words without corrupting a word that is already held. A separate combinational output reports how many bytes one line of the configured width occupies at the configured depth. A parameter chooses between two variants. In the base variant, the external select shapes depth code 4. In the extended variant, depth code 4 is always 5551 and the select is ignored.

Top module: `pixunp_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Depth codes 0 to 7 give 1, 2, 4, 8, 16, 32, 16 (565) and 16 (12-bit container) bits per pixel. A word yields exactly 32/bpp pixels. `out_valid` drops after the last one when no new word is offered.
- R3: `line_bytes` equals cols/8, cols/4, cols/2, cols, cols*4 for codes 0, 1, 2, 3, 5, and cols*2 for codes 4, 6, 7. Division truncates.
- R4: For codes 0 to 3, `pal_idx` carries the pixel value zero-extended to 8 bits. `out_rgb` is `pal_rgb`, after any channel swap.
- R5: In the base variant (EXTENDED=0), code 4 depends on the external select. Select 1 gives 5551: red bits 4:0, green 9:5, blue 14:10, and bit 15 is ignored. Select 3 gives 565 with red and blue always swapped. Selects 0 and 2 give 565 with the swap taken from `cfg_bgr`. In the extended variant, code 4 is always 5551 and the select is ignored.
- R6: The 565 layout is red bits 4:0, green 10:5, blue 15:11. The 12-bit layout is red 3:0, green 7:4, blue 11:8, with bits 15:12 ignored. The 32-bit layout is red 7:0, green 15:8, blue 23:16, with bits 31:24 ignored. Each channel is widened by a left shift with zero fill.
- R7: `out_rgb` is {red, green, blue}, with red in bits 23:16. When the swap is in effect, bits 23:16 and 7:0 exchange.
- R8: Pixel k sits at bit offset k*bpp under little-endian order. When `cfg_be_byte` is 1, it sits at 32-(k+1)*bpp, and this bit wins over `cfg_be_pix`. Otherwise, when `cfg_be_pix` is 1 and bpp < 8, pixels fill each byte from its most significant bits while bytes ascend. For bpp >= 8 the offset stays k*bpp.
- R9: A word is taken when `in_valid` and `in_ready` are both 1. `in_ready` is 1 only when no word is held, or when the held word's last pixel leaves in that cycle. A pixel stays on the outputs while `out_ready` is 0.
- R10: The configuration inputs are sampled when a word is accepted. Changing them later does not alter that word's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 3 | Depth code |
| cfg_bgr | input | 1 | Swap red and blue |
| cfg_be_byte | input | 1 | Fully big-endian word order |
| cfg_be_pix | input | 1 | Big-endian pixel order within bytes |
| mux_sel | input | 2 | External 16-bit layout select |
| cfg_cols | input | COLS_W | Pixels per line |
| line_bytes | output | COLS_W+2 | Bytes per line |
| in_valid | input | 1 | Word offered |
| in_word | input | 32 | Framebuffer word |
| in_ready | output | 1 | Word accepted this cycle |
| pal_idx | output | 8 | Palette index |
| pal_rgb | input | 24 | Palette colour for `pal_idx` |
| out_valid | output | 1 | Pixel present |
| out_rgb | output | 24 | Pixel colour |
| out_ready | input | 1 | Pixel consumer ready |

## Verification
The bench builds two copies side by side on shared stimulus: one with EXTENDED=0 and one with EXTENDED=1, both with COLS_W=12. With both copies present, one run covers all four select values in the base variant and also shows that the select has no effect in the extended one. Using 12-bit columns lets line widths up to 4095 reach every truncating division and the widest multiply.

// File: rtl/pixunp_pkg.sv
package pixunp_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    FMT_IDX, FMT_5551, FMT_565, FMT_444, FMT_888
  } pix_fmt_e;

  typedef enum logic [1:0] {
    ORD_LE, ORD_BE_BYTE, ORD_BE_PIX
  } pix_ord_e;

  typedef struct packed {
    pix_fmt_e    fmt;
    pix_ord_e    ord;
    logic [2:0]  lg;
    logic        swap;
  } pix_mode_t;

  // log2 of bits per pixel for a depth code
  function automatic logic [2:0] depth_lg(input logic [2:0] d);
    case (d)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd5: return d;
      default:                      return 3'd4;
    endcase
  endfunction

  // bit offset of pixel k inside the word
  function automatic logic [4:0] pix_offset(input pix_ord_e ord,
                                            input logic [2:0] lg,
                                            input logic [4:0] k);
    logic [5:0] lin, wid, off;
    lin = 6'(k) << lg;
    wid = 6'd1 << lg;
    case (ord)
      ORD_BE_BYTE: off = 6'd32 - (lin + wid);
      ORD_BE_PIX:  off = (lg < 3'd3) ?
                         ({lin[5:3], 3'b000} + (6'd8 - {3'b000, lin[2:0]} - wid)) : lin;
      default:     off = lin;
    endcase
    return off[4:0];
  endfunction

  // low bits of the word starting at off, masked to the pixel width
  function automatic logic [23:0] pick_field(input logic [WORD_W-1:0] w,
                                             input logic [4:0] off,
                                             input logic [2:0] lg);
    logic [23:0] m;
    case (lg)
      3'd0: m = 24'h000001;
      3'd1: m = 24'h000003;
      3'd2: m = 24'h00000F;
      3'd3: m = 24'h0000FF;
      3'd4: m = 24'h00FFFF;
      default: m = 24'hFFFFFF;
    endcase
    return 24'(w >> off) & m;
  endfunction

endpackage

// File: rtl/pixunp_mode_decode.sv
module pixunp_mode_decode
  import pixunp_pkg::*;
#(
  parameter bit EXTENDED = 1'b0
) (
  input  logic [2:0] depth,
  input  logic       bgr,
  input  logic       be_byte,
  input  logic       be_pix,
  input  logic [1:0] mux_sel,
  output pix_mode_t  mode
);

  pix_fmt_e base16_fmt;
  logic     base16_swap;

  generate
    if (EXTENDED) begin : g_ext
      assign base16_fmt  = FMT_5551;
      assign base16_swap = bgr;
      logic unused_mux;
      assign unused_mux = ^mux_sel;
    end else begin : g_base
      always_comb begin
        base16_fmt  = (mux_sel == 2'd1) ? FMT_5551 : FMT_565;
        base16_swap = (mux_sel == 2'd3) ? 1'b1 : bgr;
      end
    end
  endgenerate

  always_comb begin
    mode.lg   = depth_lg(depth);
    mode.swap = bgr;
    mode.ord  = be_byte ? ORD_BE_BYTE : (be_pix ? ORD_BE_PIX : ORD_LE);
    case (depth)
      3'd4: begin
        mode.fmt  = base16_fmt;
        mode.swap = base16_swap;
      end
      3'd5:    mode.fmt = FMT_888;
      3'd6:    mode.fmt = FMT_565;
      3'd7:    mode.fmt = FMT_444;
      default: mode.fmt = FMT_IDX;
    endcase
  end

endmodule

// File: rtl/pixunp_color_expand.sv
module pixunp_color_expand
  import pixunp_pkg::*;
(
  input  logic [23:0] field,
  input  pix_fmt_e    fmt,
  input  logic        swap,
  output logic [7:0]  pal_idx,
  input  logic [23:0] pal_rgb,
  output logic [23:0] rgb
);

  logic [7:0] r, g, b;

  assign pal_idx = field[7:0];

  always_comb begin
    case (fmt)
      FMT_5551: begin
        r = {field[4:0],   3'b000};
        g = {field[9:5],   3'b000};
        b = {field[14:10], 3'b000};
      end
      FMT_565: begin
        r = {field[4:0],   3'b000};
        g = {field[10:5],  2'b00};
        b = {field[15:11], 3'b000};
      end
      FMT_444: begin
        r = {field[3:0],  4'h0};
        g = {field[7:4],  4'h0};
        b = {field[11:8], 4'h0};
      end
      FMT_888: begin
        r = field[7:0];
        g = field[15:8];
        b = field[23:16];
      end
      default: begin
        r = pal_rgb[23:16];
        g = pal_rgb[15:8];
        b = pal_rgb[7:0];
      end
    endcase
    rgb = swap ? {b, g, r} : {r, g, b};
  end

endmodule

// File: rtl/pixunp_line_len.sv
module pixunp_line_len #(
  parameter int COLS_W = 12
) (
  input  logic [COLS_W-1:0] cols,
  input  logic [2:0]        depth,
  output logic [COLS_W+1:0] bytes
);

  localparam int BW = COLS_W + 2;

  function automatic logic [BW-1:0] calc(input logic [COLS_W-1:0] c,
                                         input logic [2:0] d);
    logic [BW-1:0] cx;
    cx = BW'(c);
    case (d)
      3'd0:    return cx >> 3;
      3'd1:    return cx >> 2;
      3'd2:    return cx >> 1;
      3'd3:    return cx;
      3'd5:    return cx << 2;
      default: return cx << 1;
    endcase
  endfunction

  assign bytes = calc(cols, depth);

endmodule

// File: rtl/pixunp_top.sv
module pixunp_top
  import pixunp_pkg::*;
#(
  parameter int COLS_W   = 12,
  parameter bit EXTENDED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_bgr,
  input  logic              cfg_be_byte,
  input  logic              cfg_be_pix,
  input  logic [1:0]        mux_sel,
  input  logic [COLS_W-1:0] cfg_cols,
  output logic [COLS_W+1:0] line_bytes,
  input  logic              in_valid,
  input  logic [31:0]       in_word,
  output logic              in_ready,
  output logic [7:0]        pal_idx,
  input  logic [23:0]       pal_rgb,
  output logic              out_valid,
  output logic [23:0]       out_rgb,
  input  logic              out_ready
);

  pix_mode_t         mode_d, mode_q;
  logic [WORD_W-1:0] word_q;
  logic [4:0]        idx_q;
  logic              held_q;

  // named events for the checker
  logic [4:0]  last_idx;
  logic        last_pix;
  logic        word_take;
  logic        pix_fire;
  logic        cur_is_idx;
  logic [2:0]  cur_lg;
  logic [4:0]  bit_off;
  logic [23:0] field;

  pixunp_mode_decode #(.EXTENDED(EXTENDED)) u_dec (
    .depth   (cfg_depth),
    .bgr     (cfg_bgr),
    .be_byte (cfg_be_byte),
    .be_pix  (cfg_be_pix),
    .mux_sel (mux_sel),
    .mode    (mode_d)
  );

  pixunp_line_len #(.COLS_W(COLS_W)) u_len (
    .cols  (cfg_cols),
    .depth (cfg_depth),
    .bytes (line_bytes)
  );

  assign last_idx   = 5'd31 >> mode_q.lg;
  assign last_pix   = (idx_q == last_idx);
  assign in_ready   = !held_q || (out_ready && last_pix);
  assign word_take  = in_valid && in_ready;
  assign pix_fire   = held_q && out_ready;
  assign out_valid  = held_q;
  assign cur_is_idx = (mode_q.fmt == FMT_IDX);
  assign cur_lg     = mode_q.lg;

  assign bit_off = pix_offset(mode_q.ord, mode_q.lg, idx_q);
  assign field   = pick_field(word_q, bit_off, mode_q.lg);

  pixunp_color_expand u_exp (
    .field   (field),
    .fmt     (mode_q.fmt),
    .swap    (mode_q.swap),
    .pal_idx (pal_idx),
    .pal_rgb (pal_rgb),
    .rgb     (out_rgb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
      mode_q <= '0;
    end else if (word_take) begin
      held_q <= 1'b1;
      idx_q  <= '0;
      word_q <= in_word;
      mode_q <= mode_d;
    end else if (pix_fire) begin
      if (last_pix) held_q <= 1'b0;
      else          idx_q  <= idx_q + 5'd1;
    end
  end

endmodule

// File: rtl/pixunp_checker.sv
module pixunp_checker #(
  parameter int COLS_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              last_pix,
  input logic [7:0]        pal_idx,
  input logic              cur_is_idx,
  input logic [2:0]        cur_lg,
  input logic [2:0]        cfg_depth,
  input logic [COLS_W-1:0] cfg_cols,
  input logic [COLS_W+1:0] line_bytes
);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

  a_r9_hold_midword: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && last_pix)) |-> !in_ready);

  a_r9_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(pal_idx)));

  a_r2_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && last_pix && !in_valid) |=> !out_valid);

  a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cur_is_idx) |-> ((16'(pal_idx) >> (5'd1 << cur_lg)) == 16'd0));

  a_r3_line_8bpp: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_depth == 3'd3) |-> (line_bytes == (COLS_W+2)'(cfg_cols)));

endmodule

bind pixunp_top pixunp_checker #(.COLS_W(COLS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .last_pix   (last_pix),
  .pal_idx    (pal_idx),
  .cur_is_idx (cur_is_idx),
  .cur_lg     (cur_lg),
  .cfg_depth  (cfg_depth),
  .cfg_cols   (cfg_cols),
  .line_bytes (line_bytes)
);

// File: tb/sim_pixunp_top.sv
`timescale 1ns/1ps
module sim_pixunp_top;

  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cfg_depth = '0;
  logic          cfg_bgr = 1'b0, cfg_be_byte = 1'b0, cfg_be_pix = 1'b0;
  logic [1:0]    mux_sel = '0;
  logic [CW-1:0] cfg_cols = '0;
  logic          in_valid = 1'b0;
  logic [31:0]   in_word = '0;
  logic          out_ready = 1'b0;

  logic [CW+1:0] lb0, lb1;
  logic          rdy0, rdy1, ov0, ov1;
  logic [7:0]    pi0, pi1;
  logic [23:0]   pr0, pr1, rgb0, rgb1;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  function automatic logic [23:0] pal_fn(input logic [7:0] i);
    return {i ^ 8'h5A, ~i, i + 8'd17};
  endfunction

  assign pr0 = pal_fn(pi0);
  assign pr1 = pal_fn(pi1);

  pixunp_top #(.COLS_W(CW), .EXTENDED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_bgr(cfg_bgr),
    .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix), .mux_sel(mux_sel),
    .cfg_cols(cfg_cols), .line_bytes(lb0), .in_valid(in_valid), .in_word(in_word),
    .in_ready(rdy0), .pal_idx(pi0), .pal_rgb(pr0), .out_valid(ov0),
    .out_rgb(rgb0), .out_ready(out_ready));

  pixunp_top #(.COLS_W(CW), .EXTENDED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_bgr(cfg_bgr),
    .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix), .mux_sel(mux_sel),
    .cfg_cols(cfg_cols), .line_bytes(lb1), .in_valid(in_valid), .in_word(in_word),
    .in_ready(rdy1), .pal_idx(pi1), .pal_rgb(pr1), .out_valid(ov1),
    .out_rgb(rgb1), .out_ready(out_ready));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bpp_of(input logic [2:0] d);
    case (d)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd5: return 32;
      default: return 16;
    endcase
  endfunction

  function automatic logic [23:0] model(input logic [31:0] w, input logic [2:0] d,
      input logic bgr, input logic bebo, input logic bepo, input logic [1:0] mux,
      input logic ext, input int k);
    int bpp, pos;
    logic [31:0] v, m;
    logic [7:0] r, g, b;
    logic sw;
    bpp = bpp_of(d);
    if (bebo)                 pos = 32 - (k + 1) * bpp;
    else if (bepo && bpp < 8) pos = ((k * bpp) / 8) * 8 + 8 - bpp - ((k * bpp) % 8);
    else                      pos = k * bpp;
    m = (bpp == 32) ? 32'hFFFF_FFFF : ((32'h1 << bpp) - 32'h1);
    v = (w >> pos) & m;
    sw = bgr;
    if (d <= 3'd3) begin
      {r, g, b} = pal_fn(v[7:0]);
    end else if (d == 3'd5) begin
      r = v[7:0]; g = v[15:8]; b = v[23:16];
    end else if (d == 3'd7) begin
      r = {v[3:0], 4'h0}; g = {v[7:4], 4'h0}; b = {v[11:8], 4'h0};
    end else if (d == 3'd4 && (ext || mux == 2'd1)) begin
      r = {v[4:0], 3'b0}; g = {v[9:5], 3'b0}; b = {v[14:10], 3'b0};
    end else begin
      r = {v[4:0], 3'b0}; g = {v[10:5], 2'b0}; b = {v[15:11], 3'b0};
      if (d == 3'd4 && mux == 2'd3) sw = 1'b1;
    end
    return sw ? {b, g, r} : {r, g, b};
  endfunction

  task automatic run_word(input logic [31:0] w, input logic [2:0] d, input logic bgr,
      input logic bebo, input logic bepo, input logic [1:0] mux, input string tag);
    int n, k;
    string t;
    logic [31:0] exp_lb;
    n = 32 / bpp_of(d);
    k = 0;
    t = tag;
    if (t == "") begin
      if (bebo || bepo)       t = "R8";
      else if (d <= 3'd3)     t = "R4";
      else if (d == 3'd4)     t = "R5";
      else                    t = "R6";
    end
    @(negedge clk);
    cfg_depth = d; cfg_bgr = bgr; cfg_be_byte = bebo; cfg_be_pix = bepo;
    mux_sel = mux; cfg_cols = CW'($urandom);
    in_word = w; in_valid = 1'b1; out_ready = 1'b0;
    #1;
    exp_lb = (32'(cfg_cols) * 32'(bpp_of(d))) / 32'd8;
    chk("R3", 32'(lb0), exp_lb);
    chk("R9", 32'(rdy0), 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    // R10: scramble configuration while the word is held
    cfg_depth = 3'($urandom); cfg_bgr = 1'($urandom); cfg_be_byte = 1'($urandom);
    cfg_be_pix = 1'($urandom); mux_sel = 2'($urandom);
    while (k < n) begin
      out_ready = ($urandom % 4) != 0;
      #1;
      chk("R9", 32'(ov0), 32'd1);
      chk(t, 32'(rgb0), 32'(model(w, d, bgr, bebo, bepo, mux, 1'b0, k)));
      chk(t, 32'(rgb1), 32'(model(w, d, bgr, bebo, bepo, mux, 1'b1, k)));
      chk("R9", 32'(rdy0), 32'(out_ready && (k == n - 1)));
      @(posedge clk);
      if (out_ready) k++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    #1;
    chk("R2", 32'(ov0), 32'd0);
    chk("R2", 32'(ov1), 32'd0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", 32'(ov0), 32'd0);
    chk("R1", 32'(rdy0), 32'd1);
    chk("R1", 32'(ov1), 32'd0);

    // directed corners
    run_word(32'h0011_2233, 3'd5, 1'b1, 1'b0, 1'b0, 2'd0, "R7");
    run_word(32'h0011_2233, 3'd5, 1'b0, 1'b0, 1'b0, 2'd0, "R7");
    run_word(32'hFFFF_7C1F, 3'd4, 1'b0, 1'b0, 1'b0, 2'd1, "R5");
    run_word(32'h1234_F81F, 3'd4, 1'b0, 1'b0, 1'b0, 2'd3, "R5");
    run_word(32'h1234_F81F, 3'd4, 1'b1, 1'b0, 1'b0, 2'd0, "R5");
    run_word(32'hA5C3_07E0, 3'd4, 1'b0, 1'b0, 1'b0, 2'd2, "R5");
    run_word(32'hF123_EABC, 3'd7, 1'b0, 1'b0, 1'b0, 2'd0, "R6");
    run_word(32'h07E0_F800, 3'd6, 1'b0, 1'b0, 1'b0, 2'd3, "R6");
    run_word(32'h8000_0001, 3'd0, 1'b0, 1'b1, 1'b1, 2'd0, "R8");
    run_word(32'h8000_0001, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0, "R8");
    run_word(32'h1B2D_3C4E, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0, "R4");
    run_word(32'hDEAD_BEEF, 3'd3, 1'b1, 1'b0, 1'b0, 2'd0, "R10");

    @(negedge clk);
    cfg_cols = 12'hFFF;
    for (int d = 0; d < 8; d++) begin
      cfg_depth = 3'(d);
      #1;
      chk("R3", 32'(lb0), (32'hFFF * 32'(bpp_of(3'(d)))) / 32'd8);
      #1;
    end

    for (int i = 0; i < 250; i++) begin
      run_word($urandom, 3'($urandom), 1'($urandom), ($urandom % 3) == 0,
               ($urandom % 3) == 0, 2'($urandom), "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule